// File: doc/BRIEF.md
# Three-channel programmable interval counter

The block holds three independent 16-bit down-counters. A host programs and reads them through one byte-wide port. A control address carries mode words and snapshot commands. Each channel has its own data address, and one further address acknowledges interrupts.

Each channel counts only on cycles where its tick input, driven by an external prescaler, is high. It also needs its gate input high. When the programmed period has elapsed, the channel raises its interrupt bit and reloads by itself, so it produces a periodic event. A snapshot command freezes the count and/or the mode byte of any set of channels, so the host can read a stable value while counting goes on.

Top module: `ivt_timer3`

## Requirements
- R1: Addresses 0, 1 and 2 reach the data port of channels 0, 1 and 2. Address 3 is the control port, and reading it returns the last mode word written to any channel. Address 4 is the acknowledge port. Reads of addresses 5 to 7 return 0.
- R2: A control write with bits [7:6] = 0..2 is a mode word for that channel. Its fields are bits [5:4] for byte access (1 = low only, 2 = high only, 3 = low then high) and bits [3:1] for the operating mode. A mode word stores the byte, stops the channel, resets both byte toggles, drops any pending snapshot, and sets both count and divisor to 0xFFFF.
- R3: In low-only access a data write sets divisor and count to the byte. In high-only access it sets them to the byte times 256. Either write starts the channel.
- R4: In low-then-high access the first data write replaces the low byte, and the channel stays stopped with count = {old high byte, new low byte}. The second write replaces the high byte, and the channel starts with count = divisor.
- R5: A running channel decrements its count on each tick where its gate is high. Its interrupt bit is set exactly N ticks after the start, where N is the divisor and a divisor of 0 means 65536.
- R6: When the operating mode equals 3, N is half the divisor (65536 for a divisor of 0), rounded down, with a minimum of 1.
- R7: At terminal count the count becomes 0xFFFF and the period restarts, so the interrupt recurs every N ticks.
- R8: While the gate is low, the count holds and no interrupt is raised. After the gate rises again, a full period of N ticks passes before the next interrupt.
- R9: A control write with bits [7:6] = 3 is a snapshot command. Bits 1, 2 and 3 pick channels 0, 1 and 2. Bit 5 = 0 captures the count and bit 4 = 0 captures the mode byte. A capture requested while one of the same kind is still unread is ignored.
- R10: In low-then-high access, a data read returns the captured mode byte first, as one byte. Next it returns the captured count, low byte then high byte, and the capture is freed after the high byte. Otherwise it returns the live count, low byte then high byte, alternating.
- R11: In low-only access a data read returns the live count's low byte, and in high-only access its high byte. In access setting 0 it returns 0.
- R12: Reading address 4 returns 0 and clears all interrupt bits. A terminal count in the same cycle still sets its bit. Writes to address 4 leave the interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte; side effects apply at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while bus_rd is high |
| tick | input | 3 | Per-channel count enable from the prescaler |
| gate | input | 3 | Per-channel gate |
| irq | output | 3 | Per-channel terminal-count interrupt, held until acknowledged |

## Verification
The period is swept over divisors 1 to 9 in both the full-period mode and the halving mode, and each setting is run for two periods. This separates the halving and rounding rules from the plain count and proves that the reload is periodic. A divisor of 0 in each mode checks the 65536 wrap. Separate sequences cover a half-loaded two-byte divisor, a gate drop in mid-count, and snapshot commands of each kind. The snapshot sequences include repeated and multi-channel snapshots, so the read priority and the ignore-while-pending rule are told apart from a plain live read.

// File: rtl/ivt_timer3.sv
module ivt_timer3 #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [2:0]        tick,
  input  logic [2:0]        gate,
  output logic [2:0]        irq
);
  localparam int NCH = 3;
  localparam int CW = 16;
  localparam int PW = CW + 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(4);

  logic [7:0]    ctrl [NCH];
  logic [CW-1:0] cnt  [NCH];
  logic [CW-1:0] div  [NCH];
  logic [CW-1:0] clat [NCH];
  logic [7:0]    slat [NCH];
  logic [PW-1:0] rem  [NCH];
  logic [NCH-1:0] armed, wtog, rtog, cpend, spend;
  logic [7:0] last_ctrl;
  logic [NCH-1:0] irq_q;

  logic [CW-1:0] ndiv [NCH];
  logic [PW-1:0] nper [NCH];
  logic [PW-1:0] cper [NCH];
  logic [NCH-1:0] wsel, dwr, narm, mw, rbs, rsel, run, tc;

  wire cw_wr  = bus_wr && bus_addr == A_CTRL;
  wire rb_cmd = cw_wr && bus_wdata[7:6] == 2'd3;
  wire ack_rd = bus_rd && bus_addr == A_ACK;

  function automatic logic [PW-1:0] period_of(input logic [CW-1:0] d, input logic [2:0] m);
    logic [PW-1:0] full;
    logic [PW-1:0] half;
    full = (d == '0) ? (PW'(1) << CW) : {1'b0, d};
    half = full >> 1;
    if (m == 3'd3) return (half == '0) ? PW'(1) : half;
    return full;
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      wsel[i] = bus_wr && bus_addr == ADDR_W'(i);
      dwr[i]  = wsel[i] && ctrl[i][5:4] != 2'd0;
      mw[i]   = cw_wr && bus_wdata[7:6] == 2'(i);
      rbs[i]  = rb_cmd && bus_wdata[i+1];
      rsel[i] = bus_rd && bus_addr == ADDR_W'(i);
      case (ctrl[i][5:4])
        2'd1:    ndiv[i] = {8'h00, bus_wdata};
        2'd2:    ndiv[i] = {bus_wdata, 8'h00};
        2'd3:    ndiv[i] = wtog[i] ? {bus_wdata, div[i][7:0]} : {div[i][15:8], bus_wdata};
        default: ndiv[i] = div[i];
      endcase
      narm[i] = ctrl[i][5:4] == 2'd1 || ctrl[i][5:4] == 2'd2 ||
                (ctrl[i][5:4] == 2'd3 && wtog[i]);
      nper[i] = period_of(ndiv[i], ctrl[i][3:1]);
      cper[i] = period_of(div[i], ctrl[i][3:1]);
      run[i]  = armed[i] && gate[i] && tick[i];
      tc[i]   = run[i] && rem[i] == PW'(1) && !mw[i] && !dwr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl[i] <= '0;
        cnt[i]  <= '0;
        div[i]  <= '0;
        clat[i] <= '0;
        slat[i] <= '0;
        rem[i]  <= PW'(1);
      end
      armed <= '0;
      wtog  <= '0;
      rtog  <= '0;
      cpend <= '0;
      spend <= '0;
      last_ctrl <= '0;
      irq_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (mw[i]) begin
          ctrl[i]  <= bus_wdata;
          armed[i] <= 1'b0;
          wtog[i]  <= 1'b0;
          rtog[i]  <= 1'b0;
          cpend[i] <= 1'b0;
          spend[i] <= 1'b0;
          cnt[i]   <= '1;
          div[i]   <= '1;
        end else begin
          if (dwr[i]) begin
            div[i] <= ndiv[i];
            cnt[i] <= ndiv[i];
            if (ctrl[i][5:4] == 2'd3) wtog[i] <= ~wtog[i];
            if (narm[i]) begin
              armed[i] <= 1'b1;
              rem[i]   <= nper[i];
            end else begin
              armed[i] <= 1'b0;
            end
          end else if (run[i]) begin
            if (rem[i] == PW'(1)) begin
              rem[i] <= cper[i];
              cnt[i] <= '1;
            end else begin
              rem[i] <= rem[i] - PW'(1);
              cnt[i] <= cnt[i] - CW'(1);
            end
          end else if (armed[i] && !gate[i]) begin
            rem[i] <= cper[i];
          end

          if (rsel[i] && ctrl[i][5:4] == 2'd3) begin
            if (spend[i]) begin
              spend[i] <= 1'b0;
            end else begin
              rtog[i] <= ~rtog[i];
              if (cpend[i] && rtog[i]) cpend[i] <= 1'b0;
            end
          end

          if (rbs[i] && !bus_wdata[5] && !cpend[i]) begin
            clat[i]  <= cnt[i];
            cpend[i] <= 1'b1;
          end
          if (rbs[i] && !bus_wdata[4] && !spend[i]) begin
            slat[i]  <= ctrl[i];
            spend[i] <= 1'b1;
          end
        end
      end
      if (cw_wr && !rb_cmd) last_ctrl <= bus_wdata;
      irq_q <= (ack_rd ? '0 : irq_q) | tc;
    end
  end

  logic [1:0] ch;
  assign ch = bus_addr[1:0];

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr < A_CTRL) begin
      case (ctrl[ch][5:4])
        2'd1: bus_rdata = cnt[ch][7:0];
        2'd2: bus_rdata = cnt[ch][15:8];
        2'd3: begin
          if (spend[ch])      bus_rdata = slat[ch];
          else if (cpend[ch]) bus_rdata = rtog[ch] ? clat[ch][15:8] : clat[ch][7:0];
          else                bus_rdata = rtog[ch] ? cnt[ch][15:8] : cnt[ch][7:0];
        end
        default: bus_rdata = 8'h00;
      endcase
    end else if (bus_addr == A_CTRL) begin
      bus_rdata = last_ctrl;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/ivt_timer3_chk.sv
module ivt_timer3_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic [2:0] tick,
  input logic [2:0] gate,
  input logic [2:0] irq
);
  a_r12_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4) |-> bus_rdata == 8'h00);

  a_r12_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4 && tick == 3'b000) |=> irq == 3'b000);

  a_r12_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && tick == 3'b000) |=> $stable(irq));

  a_r5_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == 3'b000) |=> (irq & ~$past(irq)) == 3'b000);

  a_r8_gate_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick & gate) == 3'b000) |=> (irq & ~$past(irq)) == 3'b000);

  a_r1_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > 3'd4) |-> bus_rdata == 8'h00);
endmodule

bind ivt_timer3 ivt_timer3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .tick(tick), .gate(gate), .irq(irq)
);

// File: tb/ivt_timer3_tb.sv
`timescale 1ns/1ps
module ivt_timer3_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [2:0] tick = 0, gate = 3'b111;
  logic [2:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ivt_timer3 u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .gate(gate), .irq(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi); v = {hi, lo};
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = m;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic run_to_irq(input int c, input int limit, output int n);
    n = 0;
    @(negedge clk); tick = 3'(1 << c);
    while (n < limit) begin
      @(negedge clk); n++;
      if (irq[c]) break;
    end
    tick = 0;
  endtask

  task automatic ack();
    logic [7:0] d;
    rd(3'd4, d);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    int n, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(irq == 0, "R12 reset irq", irq, 0);
    rd(3'd4, b); check(b == 0, "R12 ack read", b, 0);
    rd(3'd0, b); check(b == 0, "R11 reset access0 read", b, 0);
    rd(3'd6, b); check(b == 0, "R1 unused read", b, 0);

    wr(3'd3, 8'h34);
    rd(3'd3, b); check(b == 8'h34, "R1 control readback", b, 8'h34);
    rd16(3'd0, v); check(v == 16'hFFFF, "R2 mode word count", v, 16'hFFFF);

    wr(3'd0, 8'h05);
    rd16(3'd0, v); check(v == 16'hFF05, "R4 low byte only", v, 16'hFF05);
    pulse(3'b001, 3);
    rd16(3'd0, v); check(v == 16'hFF05, "R4 stopped before high byte", v, 16'hFF05);
    check(irq[0] == 0, "R4 no irq half loaded", irq, 0);
    wr(3'd0, 8'h00);
    rd16(3'd0, v); check(v == 16'h0005, "R4 full load", v, 5);
    pulse(3'b001, 4);
    rd16(3'd0, v); check(v == 16'h0001, "R5 decrement", v, 1);
    check(irq[0] == 0, "R5 no early irq", irq, 0);
    pulse(3'b001, 1);
    check(irq[0] == 1, "R5 irq at terminal count", irq, 1);
    rd16(3'd0, v); check(v == 16'hFFFF, "R7 count after terminal", v, 16'hFFFF);
    wr(3'd4, 8'hAA);
    check(irq[0] == 1, "R12 ack write ignored", irq, 1);
    rd(3'd4, b); check(b == 0, "R12 ack value", b, 0);
    check(irq == 0, "R12 ack clears", irq, 0);

    for (int md = 2; md <= 3; md++) begin
      for (int d = 1; d <= 9; d++) begin
        wr(3'd3, {2'b01, 2'b01, 3'(md), 1'b0});
        wr(3'd1, 8'(d));
        ack();
        exp = (md == 3) ? ((d / 2 == 0) ? 1 : d / 2) : d;
        run_to_irq(1, 100, n);
        check(n == exp, (md == 3) ? "R6 half period" : "R5 period", n, exp);
        ack();
        run_to_irq(1, 100, n);
        check(n == exp, "R7 periodic reload", n, exp);
      end
    end

    wr(3'd3, 8'h54); wr(3'd1, 8'h07);
    rd(3'd1, b); check(b == 8'h07, "R11 low-only read", b, 7);
    wr(3'd3, 8'h64); wr(3'd1, 8'h01);
    rd(3'd1, b); check(b == 8'h01, "R11 high-only read", b, 1);
    ack();
    run_to_irq(1, 1000, n); check(n == 256, "R3 high-only divisor", n, 256);

    wr(3'd3, 8'h94); wr(3'd2, 8'h00); ack();
    run_to_irq(2, 70000, n); check(n == 65536, "R5 divisor zero", n, 65536);
    wr(3'd3, 8'h96); wr(3'd2, 8'h00); ack();
    run_to_irq(2, 70000, n); check(n == 32768, "R6 divisor zero halved", n, 32768);

    wr(3'd3, 8'h34); wr(3'd0, 8'd10); wr(3'd0, 8'h00); ack();
    pulse(3'b001, 3);
    gate = 3'b110;
    pulse(3'b001, 5);
    rd16(3'd0, v); check(v == 16'd7, "R8 count frozen", v, 7);
    check(irq[0] == 0, "R8 no irq gated", irq, 0);
    gate = 3'b111;
    run_to_irq(0, 100, n); check(n == 10, "R8 full period after gate", n, 10);

    wr(3'd3, 8'h34); wr(3'd0, 8'h20); wr(3'd0, 8'h00);
    pulse(3'b001, 2);
    wr(3'd3, 8'hD2);
    pulse(3'b001, 3);
    wr(3'd3, 8'hD2);
    rd16(3'd0, v); check(v == 16'h001E, "R9 latched count held", v, 16'h1E);
    rd16(3'd0, v); check(v == 16'h001B, "R10 live after latch", v, 16'h1B);
    wr(3'd3, 8'hE2);
    rd(3'd0, b); check(b == 8'h34, "R10 status first", b, 8'h34);
    rd16(3'd0, v); check(v == 16'h001B, "R10 live after status", v, 16'h1B);
    wr(3'd3, 8'hC2);
    rd(3'd0, b); check(b == 8'h34, "R9 status and count", b, 8'h34);
    pulse(3'b001, 1);
    rd16(3'd0, v); check(v == 16'h001B, "R10 count after status", v, 16'h1B);
    wr(3'd3, 8'h74); wr(3'd1, 8'h40); wr(3'd1, 8'h00);
    wr(3'd3, 8'hD6);
    pulse(3'b011, 1);
    rd16(3'd1, v); check(v == 16'h0040, "R9 multi latch ch1", v, 16'h40);
    rd16(3'd0, v); check(v == 16'h001A, "R9 multi latch ch0", v, 16'h1A);
    rd16(3'd0, v); check(v == 16'h0019, "R10 live ch0", v, 16'h19);

    wr(3'd3, 8'h80);
    rd(3'd2, b); check(b == 0, "R11 access0 read", b, 0);
    rd(3'd3, b); check(b == 8'h80, "R2 mode word stored", b, 8'h80);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule